// File: doc/BRIEF.md
# Working-Set Clock Victim Selector

This block picks which page frame to give up when a new page must be brought in. The frames sit on a ring that a single pointer (the hand) walks, one frame per clock cycle. Each frame carries a touched flag, a dirty flag and a timestamp of when it was last seen in use. The sweep clears touched flags as it passes and asks for dirty, untouched frames to be copied out. It stops at the first clean, untouched frame whose age is larger than the working-set window. Age is the current virtual time minus the timestamp.

The host keeps the flags up to date through a reference port (a read or a write to a frame) and a write-back completion port. It starts a sweep with a one-cycle request, then waits for a one-cycle done pulse that comes with the chosen frame index. Write-back requests come out as one-cycle pulses with a frame index while the sweep runs. The copy itself happens outside the block. When the hand gets back to the frame where the sweep began, explicit lap rules decide how the sweep ends, so it never spins without purpose.

Top module: `wsc_victim_sel`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `wb_req_o` are 0 and `hand_o` is 0. Every frame has its touched and dirty flags clear and no timestamp; a frame without a timestamp counts as older than any window.
- R2: A request seen while idle starts a sweep at the frame under the hand, and `busy_o` is 1 from the next cycle. Each sweep cycle examines one frame. While the sweep continues, `hand_o` moves to (hand+1) mod NFRAMES every cycle.
- R3: A frame examined with its touched flag set has the flag cleared and its timestamp set to `now_i`. The hand then moves on; the frame is not chosen and gets no write-back request.
- R4: A frame examined with touched clear, dirty clear and age greater than `tau_i` is chosen. `done_o` pulses for one cycle on the cycle after that examination, with `victim_o` holding the frame. `hand_o` then rests at (victim+1) mod NFRAMES and `busy_o` returns to 0.
- R5: Age is (`now_i` − timestamp) modulo 2^TIME_W. An age equal to `tau_i` does not count as old.
- R6: On the first lap, a frame examined with touched clear and dirty set produces a one-cycle `wb_req_o` pulse, with `wb_idx_o` equal to that frame. That frame is not chosen.
- R7: If at least one write-back was requested on the first lap, the sweep goes on past its start frame. It chooses the first frame found with both touched and dirty clear, whatever its age, and requests no further write-backs.
- R8: If the hand gets back to the start frame with no write-back requested, the sweep spends one more cycle deciding and ends there. It chooses the first frame of the first lap that had its dirty flag clear. If there is none, it chooses the start frame and, if that frame is dirty, pulses `wb_req_o` for it together with `done_o`.
- R9: A write-back completion clears the dirty flag of the named frame, so later sweeps treat the frame as clean.
- R10: A reference sets the frame's touched flag and, for a write, its dirty flag. A reference wins over a sweep clearing the same frame in the same cycle. A write reference wins over a completion on the same frame in the same cycle.
- R11: A request that arrives while a sweep is running is ignored: the sweep's result is unchanged and no second sweep follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now_i | input | TIME_W | Current virtual time |
| tau_i | input | TIME_W | Working-set window |
| ref_vld_i | input | 1 | Frame reference strobe |
| ref_idx_i | input | $clog2(NFRAMES) | Referenced frame |
| ref_wr_i | input | 1 | Reference is a write (sets dirty) |
| wbd_vld_i | input | 1 | Write-back completion strobe |
| wbd_idx_i | input | $clog2(NFRAMES) | Frame whose write-back finished |
| req_i | input | 1 | Start a victim sweep |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse: victim_o valid |
| victim_o | output | $clog2(NFRAMES) | Chosen frame |
| wb_req_o | output | 1 | One-cycle write-back request |
| wb_idx_o | output | $clog2(NFRAMES) | Frame to write back |
| hand_o | output | $clog2(NFRAMES) | Current hand position |

## Verification
Every result comes from a register. The first frame is examined on the edge after the request is taken, and the outcome of the k-th examination shows on the outputs just after edge k. An ending decided at the start frame takes one more cycle than the frames walked. The bench drives and samples on falling edges and counts examinations from the request to `done_o`. It compares that count, the victim, the set of write-back indices seen and the final hand position with a model of the flags and timestamps kept in the bench. It drives one reference collision and one mid-sweep request at an exact examination cycle, so the outcome depends on which update wins.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [0:0] {
    SWEEP_IDLE = 1'b0,
    SWEEP_SCAN = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/wsc_frame_store.sv
module wsc_frame_store #(
  parameter int NFRAMES = 8,
  parameter int TIME_W  = 16,
  parameter int IW      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] now_i,
  input  logic              ref_vld_i,
  input  logic [IW-1:0]     ref_idx_i,
  input  logic              ref_wr_i,
  input  logic              wbd_vld_i,
  input  logic [IW-1:0]     wbd_idx_i,
  input  logic              sweep_clr_i,
  input  logic [IW-1:0]     sel_idx_i,
  output logic              sel_ref_o,
  output logic              sel_mod_o,
  output logic              sel_seen_o,
  output logic [TIME_W-1:0] sel_time_o
);
  logic [NFRAMES-1:0] touched;
  logic [NFRAMES-1:0] dirty;
  logic [NFRAMES-1:0] seen;
  logic [TIME_W-1:0]  stamp_mem [NFRAMES];

  for (genvar g = 0; g < NFRAMES; g++) begin : g_frame
    logic t_q, d_q, s_q;
    logic hit_ref, hit_wr, hit_done, hit_clr;
    assign hit_ref  = ref_vld_i && (ref_idx_i == IW'(g));
    assign hit_wr   = hit_ref && ref_wr_i;
    assign hit_done = wbd_vld_i && (wbd_idx_i == IW'(g));
    assign hit_clr  = sweep_clr_i && (sel_idx_i == IW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        t_q <= 1'b0;
        d_q <= 1'b0;
        s_q <= 1'b0;
      end else begin
        // a reference outranks the sweep clearing the same frame
        if (hit_ref)      t_q <= 1'b1;
        else if (hit_clr) t_q <= 1'b0;
        // a write outranks a completion on the same frame
        if (hit_wr)        d_q <= 1'b1;
        else if (hit_done) d_q <= 1'b0;
        if (hit_clr)       s_q <= 1'b1;
      end
    end
    assign touched[g] = t_q;
    assign dirty[g]   = d_q;
    assign seen[g]    = s_q;
  end

  // timestamp store: one write port and one read port, both at the hand
  always_ff @(posedge clk) begin
    if (sweep_clr_i) stamp_mem[sel_idx_i] <= now_i;
  end

  assign sel_time_o = stamp_mem[sel_idx_i];
  assign sel_ref_o  = touched[sel_idx_i];
  assign sel_mod_o  = dirty[sel_idx_i];
  assign sel_seen_o = seen[sel_idx_i];
endmodule

// File: rtl/wsc_age_check.sv
module wsc_age_check #(
  parameter int TIME_W = 16
) (
  input  logic [TIME_W-1:0] now_i,
  input  logic [TIME_W-1:0] stamp_i,
  input  logic              seen_i,
  input  logic [TIME_W-1:0] tau_i,
  output logic              old_o
);
  logic [TIME_W-1:0] age;
  assign age   = now_i - stamp_i;
  assign old_o = !seen_i || (age > tau_i);
endmodule

// File: rtl/wsc_sweep.sv
module wsc_sweep
  import wsc_pkg::*;
#(
  parameter int NFRAMES = 8,
  parameter int IW      = 3,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic          cur_ref_i,
  input  logic          cur_mod_i,
  input  logic          cur_old_i,
  output logic          clr_o,
  output logic [IW-1:0] hand_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [IW-1:0] victim_o,
  output logic          wb_req_o,
  output logic [IW-1:0] wb_idx_o
);
  sweep_state_e  state_q;
  logic [IW-1:0] hand_q, cand_idx_q, pick_idx;
  logic [CW-1:0] steps_q;
  logic          lap2_q, sched_q, cand_v_q;
  logic          scanning, wrap, use_lap2, lap_end_pick;
  logic          pick, adv, wb, cand_take;

  function automatic logic [IW-1:0] step_fwd(input logic [IW-1:0] h);
    return (h == IW'(NFRAMES - 1)) ? '0 : h + 1'b1;
  endfunction

  assign scanning     = (state_q == SWEEP_SCAN);
  assign wrap         = !lap2_q && (steps_q == CW'(NFRAMES));
  assign use_lap2     = lap2_q || (wrap && sched_q);
  assign lap_end_pick = wrap && !sched_q;

  always_comb begin
    pick      = 1'b0;
    pick_idx  = hand_q;
    adv       = 1'b0;
    wb        = 1'b0;
    clr_o     = 1'b0;
    cand_take = 1'b0;
    if (scanning) begin
      if (lap_end_pick) begin
        pick     = 1'b1;
        pick_idx = cand_v_q ? cand_idx_q : hand_q;
        wb       = !cand_v_q && cur_mod_i;
      end else if (cur_ref_i) begin
        clr_o     = 1'b1;
        adv       = 1'b1;
        cand_take = !use_lap2 && !cand_v_q && !cur_mod_i;
      end else if (!cur_mod_i && (use_lap2 || cur_old_i)) begin
        pick = 1'b1;
      end else if (!cur_mod_i) begin
        adv       = 1'b1;
        cand_take = !cand_v_q;
      end else begin
        adv = 1'b1;
        wb  = !use_lap2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SWEEP_IDLE;
      hand_q     <= '0;
      steps_q    <= '0;
      lap2_q     <= 1'b0;
      sched_q    <= 1'b0;
      cand_v_q   <= 1'b0;
      cand_idx_q <= '0;
      done_o     <= 1'b0;
      victim_o   <= '0;
      wb_req_o   <= 1'b0;
      wb_idx_o   <= '0;
    end else begin
      done_o   <= 1'b0;
      wb_req_o <= 1'b0;
      if (!scanning) begin
        if (req_i) begin
          state_q  <= SWEEP_SCAN;
          steps_q  <= '0;
          lap2_q   <= 1'b0;
          sched_q  <= 1'b0;
          cand_v_q <= 1'b0;
        end
      end else begin
        if (wb) begin
          wb_req_o <= 1'b1;
          wb_idx_o <= hand_q;
          sched_q  <= 1'b1;
        end
        if (cand_take) begin
          cand_v_q   <= 1'b1;
          cand_idx_q <= hand_q;
        end
        if (use_lap2) lap2_q <= 1'b1;
        if (adv) begin
          hand_q <= step_fwd(hand_q);
          if (steps_q != CW'(NFRAMES)) steps_q <= steps_q + 1'b1;
        end
        if (pick) begin
          done_o   <= 1'b1;
          victim_o <= pick_idx;
          hand_q   <= step_fwd(pick_idx);
          state_q  <= SWEEP_IDLE;
        end
      end
    end
  end

  assign hand_o = hand_q;
  assign busy_o = scanning;
endmodule

// File: rtl/wsc_victim_sel.sv
module wsc_victim_sel #(
  parameter int NFRAMES = 8,
  parameter int TIME_W  = 16,
  localparam int IW     = (NFRAMES > 1) ? $clog2(NFRAMES) : 1,
  localparam int CW     = $clog2(NFRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] now_i,
  input  logic [TIME_W-1:0] tau_i,
  input  logic              ref_vld_i,
  input  logic [IW-1:0]     ref_idx_i,
  input  logic              ref_wr_i,
  input  logic              wbd_vld_i,
  input  logic [IW-1:0]     wbd_idx_i,
  input  logic              req_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [IW-1:0]     victim_o,
  output logic              wb_req_o,
  output logic [IW-1:0]     wb_idx_o,
  output logic [IW-1:0]     hand_o
);
  logic              clr;
  logic              cur_ref, cur_mod, cur_seen, cur_old;
  logic [TIME_W-1:0] cur_time;

  wsc_frame_store #(.NFRAMES(NFRAMES), .TIME_W(TIME_W), .IW(IW)) u_store (
    .clk(clk), .rst(rst), .now_i(now_i),
    .ref_vld_i(ref_vld_i), .ref_idx_i(ref_idx_i), .ref_wr_i(ref_wr_i),
    .wbd_vld_i(wbd_vld_i), .wbd_idx_i(wbd_idx_i),
    .sweep_clr_i(clr), .sel_idx_i(hand_o),
    .sel_ref_o(cur_ref), .sel_mod_o(cur_mod),
    .sel_seen_o(cur_seen), .sel_time_o(cur_time)
  );

  wsc_age_check #(.TIME_W(TIME_W)) u_age (
    .now_i(now_i), .stamp_i(cur_time), .seen_i(cur_seen),
    .tau_i(tau_i), .old_o(cur_old)
  );

  wsc_sweep #(.NFRAMES(NFRAMES), .IW(IW), .CW(CW)) u_sweep (
    .clk(clk), .rst(rst), .req_i(req_i),
    .cur_ref_i(cur_ref), .cur_mod_i(cur_mod), .cur_old_i(cur_old),
    .clr_o(clr), .hand_o(hand_o), .busy_o(busy_o), .done_o(done_o),
    .victim_o(victim_o), .wb_req_o(wb_req_o), .wb_idx_o(wb_idx_o)
  );
endmodule

// File: rtl/wsc_victim_sel_chk.sv
module wsc_victim_sel_chk #(
  parameter int NFRAMES = 8,
  localparam int IW     = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          busy_o,
  input logic          done_o,
  input logic [IW-1:0] victim_o,
  input logic          wb_req_o,
  input logic [IW-1:0] hand_o
);
  function automatic logic [IW-1:0] nx(input logic [IW-1:0] h);
    return (h == IW'(NFRAMES - 1)) ? '0 : h + 1'b1;
  endfunction

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy_o && !done_o && !wb_req_o && hand_o == '0));

  a_r2_hand_step: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> (hand_o == nx($past(hand_o))));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !$past(busy_o) && !$past(rst)) |-> $stable(hand_o));

  a_r4_rest_past_victim: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && hand_o == nx(victim_o)));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r6_wb_in_sweep: assert property (@(posedge clk) disable iff (rst)
    wb_req_o |-> $past(busy_o));
endmodule

bind wsc_victim_sel wsc_victim_sel_chk #(.NFRAMES(NFRAMES)) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .done_o(done_o),
  .victim_o(victim_o), .wb_req_o(wb_req_o), .hand_o(hand_o)
);

// File: tb/tb_wsc_victim_sel.sv
module tb_wsc_victim_sel;
  localparam int N  = 4;
  localparam int TW = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TW-1:0] now_i = '0, tau_i = '0;
  logic ref_vld_i = 0, ref_wr_i = 0, wbd_vld_i = 0, req_i = 0;
  logic [IW-1:0] ref_idx_i = '0, wbd_idx_i = '0;
  logic busy_o, done_o, wb_req_o;
  logic [IW-1:0] victim_o, wb_idx_o, hand_o;

  int checks = 0, fails = 0;

  // bench-side picture of the frames
  bit mr[N], mm[N], ms[N];
  logic [TW-1:0] mt[N];
  int mh = 0;
  int ev, ek, ewbm, ewbc;

  always #5 clk = ~clk;

  wsc_victim_sel #(.NFRAMES(N), .TIME_W(TW)) dut (
    .clk(clk), .rst(rst), .now_i(now_i), .tau_i(tau_i),
    .ref_vld_i(ref_vld_i), .ref_idx_i(ref_idx_i), .ref_wr_i(ref_wr_i),
    .wbd_vld_i(wbd_vld_i), .wbd_idx_i(wbd_idx_i), .req_i(req_i),
    .busy_o(busy_o), .done_o(done_o), .victim_o(victim_o),
    .wb_req_o(wb_req_o), .wb_idx_o(wb_idx_o), .hand_o(hand_o)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // expected sweep outcome from the requirements, updating the picture
  function automatic void model_sweep();
    int h = mh, cnt = 0, ci = 0, k = 0;
    bit lap2 = 0, sched = 0, cv = 0;
    ev = -1; ewbm = 0; ewbc = 0;
    while (k < 64) begin
      bit wrap, ul2, old;
      logic [TW-1:0] age;
      k++;
      wrap = !lap2 && cnt == N;
      ul2  = lap2 || (wrap && sched);
      if (wrap && !sched) begin
        ev = cv ? ci : h;
        if (!cv && mm[h]) begin ewbm |= (1 << h); ewbc++; end
        break;
      end
      if (ul2) lap2 = 1;
      age = now_i - mt[h];
      old = !ms[h] || (age > tau_i);
      if (mr[h]) begin
        mr[h] = 0; ms[h] = 1; mt[h] = now_i;
        if (!ul2 && !cv && !mm[h]) begin cv = 1; ci = h; end
      end else if (!mm[h] && (ul2 || old)) begin
        ev = h;
        break;
      end else if (!mm[h]) begin
        if (!cv) begin cv = 1; ci = h; end
      end else if (!ul2) begin
        ewbm |= (1 << h); ewbc++; sched = 1;
      end
      h = (h + 1) % N;
      if (!lap2 && cnt < N) cnt++;
    end
    ek = k;
    if (ev >= 0) mh = (ev + 1) % N;
  endfunction

  task automatic apply_upd(input bit rv, input int ri, input bit rw,
                           input bit dv, input int di);
    @(negedge clk);
    ref_vld_i = rv; ref_idx_i = IW'(ri); ref_wr_i = rw;
    wbd_vld_i = dv; wbd_idx_i = IW'(di);
    @(negedge clk);
    ref_vld_i = 0; ref_wr_i = 0; wbd_vld_i = 0;
    if (dv) mm[di] = 0;
    if (rv) begin mr[ri] = 1; if (rw) mm[ri] = 1; end
  endtask

  task automatic run_sweep(input string rq, input bit cref, input int cidx,
                           input bit cwr, input bit midreq);
    int k = 0, wbm = 0, wbc = 0;
    bit got = 0;
    model_sweep();
    @(negedge clk); req_i = 1;
    @(negedge clk); req_i = 0;
    while (!got && k < 64) begin
      ref_vld_i = cref && (k == 0);
      ref_idx_i = IW'(cidx);
      ref_wr_i  = cwr && (k == 0);
      req_i     = midreq && (k == 1);
      @(negedge clk);
      k++;
      if (wb_req_o) begin wbm |= (1 << wb_idx_o); wbc++; end
      if (done_o) got = 1;
    end
    ref_vld_i = 0; ref_wr_i = 0; req_i = 0;
    chk(rq, "done seen", int'(got), 1);
    chk(rq, "cycles to done", k, ek);
    chk(rq, "victim", int'(victim_o), ev);
    chk(rq, "write-back index mask", wbm, ewbm);
    chk(rq, "write-back count", wbc, ewbc);
    chk("R2", "hand after sweep", int'(hand_o), mh);
    chk("R2", "busy after done", int'(busy_o), 0);
    if (cref) begin mr[cidx] = 1; if (cwr) mm[cidx] = 1; end
    if (midreq) begin
      int extra = 0;
      repeat (3) begin @(negedge clk); extra += int'(done_o) + int'(busy_o); end
      chk("R11", "activity after ignored request", extra, 0);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mr[i] = 0; mm[i] = 0; ms[i] = 0; mt[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "wb_req", int'(wb_req_o), 0);
    chk("R1", "hand", int'(hand_o), 0);

    // R1 R4: never-stamped frame 0 is old at once
    now_i = 8'd10; tau_i = 8'd5;
    run_sweep("R1 R4", 0, 0, 0, 0);
    chk("R4", "first victim", int'(victim_o), 0);

    // R3 R8: all touched, clean -> lap end picks first clean frame
    for (int i = 0; i < N; i++) apply_upd(1, i, 0, 0, 0);
    now_i = 8'd20;
    run_sweep("R3 R8", 0, 0, 0, 0);
    chk("R8", "lap-end clean pick", int'(victim_o), 1);

    // R5: age equal to tau is young
    now_i = 8'd25;
    run_sweep("R5", 0, 0, 0, 0);
    chk("R5", "age==tau not old", int'(victim_o), 2);
    now_i = 8'd26;
    run_sweep("R5", 0, 0, 0, 0);
    chk("R5", "age>tau old", int'(victim_o), 3);

    // R8: all touched and dirty -> start frame chosen and written back
    for (int i = 0; i < N; i++) apply_upd(1, i, 1, 0, 0);
    now_i = 8'd40;
    run_sweep("R8", 0, 0, 0, 0);

    // R6 R9: completion cleans frame 2
    apply_upd(0, 0, 0, 1, 2);
    now_i = 8'd140; tau_i = 8'd10;
    run_sweep("R6 R9", 0, 0, 0, 0);
    chk("R9", "cleaned frame chosen", int'(victim_o), 2);

    // R7: dirty frames scheduled, sweep continues to young clean frame
    now_i = 8'd145; tau_i = 8'd200;
    run_sweep("R7", 0, 0, 0, 0);
    chk("R7", "second-lap pick", int'(victim_o), 2);

    // R10: write reference on the frame being cleared in the same cycle
    for (int i = 0; i < N; i++) apply_upd(1, i, 0, 1, i);
    now_i = 8'd150;
    run_sweep("R10", 1, 3, 1, 0);
    now_i = 8'd151;
    run_sweep("R10", 0, 0, 0, 0);
    // R10: write beats completion on the same frame
    apply_upd(1, 1, 1, 1, 1);
    now_i = 8'd152;
    run_sweep("R10", 0, 0, 0, 0);

    // R11: request during a sweep
    for (int i = 0; i < N; i++) apply_upd(1, i, 0, 0, 0);
    now_i = 8'd160;
    run_sweep("R11", 0, 0, 0, 1);

    // mixed patterns, time wraps modulo 2^TW (R5)
    for (int it = 0; it < 250; it++) begin
      int nref;
      bit alld, allt;
      now_i = now_i + TW'($urandom % 60);
      tau_i = TW'($urandom % 40);
      nref = int'($urandom % 5);
      for (int j = 0; j < nref; j++)
        apply_upd(1, int'($urandom % N), bit'($urandom % 2),
                  bit'($urandom % 4 == 0), int'($urandom % N));
      if ($urandom % 2 == 0) apply_upd(0, 0, 0, 1, int'($urandom % N));
      alld = 1; allt = 1;
      for (int i = 0; i < N; i++) begin alld &= mm[i]; allt &= mr[i]; end
      if (alld && !allt) apply_upd(0, 0, 0, 1, int'($urandom % N));
      run_sweep("R2 R3 R4 R5 R6 R7 R8 R9 R10", 0, 0, 0, (it % 7) == 3);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule